// File: doc/BRIEF.md
# Serial DAC Control Front-End

This block holds the digital control logic for a 14-bit voltage-output DAC. A three-wire serial port has an active-low select, a serial clock and a data line. It shifts in 16-bit words, most significant bit first. The two leading bits of each word are a command and the remaining fourteen are a code. Two registers sit behind the port. A staging register takes new codes, and an output register drives the converter. The command decides which of the two registers a completed word updates.

The block also tracks a power-saving sleep state. Sleep can be requested by a serial command or by a sleep pin. Both requests take effect only while an enable pin is high. A falling edge on the enable pin forces the block awake. The output code register keeps its value through sleep, so the converter resumes at its previous level when the block wakes. A serial data-out pin presents the oldest bit held in the shift register, so several devices can be chained on one select line. All pins are sampled by the block's system clock through two-stage synchronisers. The serial clock must therefore run well below the system clock.

Top module: `dac_serial_ctrl`

## Requirements
- R1: After reset, `dac_code` is 0, `active` is 1 and `sdo` is 0.
- R2: A word whose command bits [15:14] are 00 writes bits [13:0] into the staging register and leaves `dac_code` unchanged.
- R3: A word with command 01 copies the staging register into the output register, which is visible on `dac_code`. Its data bits are not used.
- R4: A word with command 10 writes bits [13:0] into both registers at once. It also wakes the block from sleep, unless a sleep request from the pin is held at that moment.
- R5: A word with command 11 puts the block to sleep (`active` = 0) when `sleep_allow` is high. Its data bits are ignored, and both registers keep their contents.
- R6: A word is acted on at the rising edge of `cs_n` only if exactly 16 rising `sclk` edges arrived while `cs_n` was low. Frames of any other length change nothing.
- R7: While `sleep_allow` is high, a high `sleep_pin` puts the block to sleep. Lowering `sleep_pin` afterwards does not wake it.
- R8: While `sleep_allow` is low, neither `sleep_pin` nor command 11 can put the block to sleep.
- R9: A falling edge on `sleep_allow` wakes the block, and `dac_code` still holds the value it had before sleep.
- R10: During sleep, serial words are still accepted. Commands 00 and 01 update the registers, and the block stays asleep.
- R11: On each falling `sclk` edge while `cs_n` is low, `sdo` takes the oldest bit in the 16-bit shift register. After 16 or more bits, `sdo` therefore shows the bit sent 16 positions earlier.
- R12: Bits are shifted in most significant bit first. The full code range from 0 to 16383 (0x3FFF) reaches `dac_code`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, sampling all pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial frame select, active low |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| sleep_pin | input | 1 | Hardware sleep request, active high |
| sleep_allow | input | 1 | Sleep enable; low blocks sleep, falling edge wakes |
| sdo | output | 1 | Serial data out for chaining |
| dac_code | output | 14 | Code applied to the converter |
| active | output | 1 | 1 = converter powered, 0 = outputs high-impedance |

## Verification
A corrupted staging register does not show up until the next copy command, so every staging write is followed later by a command 01 and a check of `dac_code`. A wrong bit count shows up at the next rising edge of `cs_n`: a good word is dropped, or a bad one is applied. Both cases appear on `dac_code` a few system clocks later. The sleep state is visible on `active` within a handful of cycles. The bench drives pin edges and writes that must not change that state, and it confirms that `dac_code` stays the same across each sleep and wake.

// File: rtl/dac_ctrl_pkg.sv
// Package: shared sizes and the command encoding for the serial DAC front-end.
package dac_ctrl_pkg;
    localparam int CODE_W = 14;
    localparam int CMD_W  = 2;
    localparam int WORD_W = CODE_W + CMD_W;

    // Command carried in the top two bits of every serial word.
    typedef enum logic [CMD_W-1:0] {
        CMD_STAGE = 2'b00,  // write staging register only
        CMD_XFER  = 2'b01,  // staging register -> output register
        CMD_BOTH  = 2'b10,  // write both, wake
        CMD_SLEEP = 2'b11   // request sleep, data ignored
    } cmd_e;
endpackage

// File: rtl/pin_sync.sv
// Module: pin_sync
// Brings WIDTH asynchronous pins into the clk domain through STAGES flops and
// reports the level plus one-cycle rise and fall pulses for each pin.
// Assumes: pins are held for at least STAGES+1 clk cycles per level; STAGES >= 2.
module pin_sync #(
    parameter int              WIDTH   = 5,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    generate
        for (genvar gi = 0; gi < WIDTH; gi++) begin : g_pin
            logic [STAGES-1:0] chain_q;
            logic              prev_q;

            // Shift the pin through the synchroniser and keep one older copy.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= {STAGES{RST_VAL[gi]}};
                    prev_q  <= RST_VAL[gi];
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], pin_i[gi]};
                    prev_q  <= chain_q[STAGES-1];
                end
            end

            assign lvl_o[gi]  = chain_q[STAGES-1];
            assign rise_o[gi] = chain_q[STAGES-1] & ~prev_q;
            assign fall_o[gi] = ~chain_q[STAGES-1] & prev_q;
        end
    endgenerate
endmodule

// File: rtl/serial_shifter.sv
// Module: serial_shifter
// Collects serial bits into a WORD_W shift register, counts the clocks of the
// current frame and flags a complete word when select rises after exactly
// WORD_W clocks. Drives the chaining output from the register's oldest bit.
// Assumes: edge pulses come from pin_sync; select and clock edges never coincide.
module serial_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_lvl_i,   // synchronised cs_n level
    input  logic              sel_fall_i,
    input  logic              sel_rise_i,
    input  logic              sck_rise_i,
    input  logic              sck_fall_i,
    input  logic              sdi_lvl_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_valid_o,
    output logic              sdo_o
);
    localparam int CNT_MAX = WORD_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              valid_q;
    logic              sdo_q;
    logic              frame_on;

    assign frame_on = ~sel_lvl_i;

    // Shift data on rising clock inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (frame_on && sck_rise_i) begin
            shreg_q <= {shreg_q[WORD_W-2:0], sdi_lvl_i};
        end
    end

    // Count clocks of the frame, saturating one past a full word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sel_fall_i) begin
            cnt_q <= '0;
        end else if (frame_on && sck_rise_i && cnt_q != CNT_W'(CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag a complete word at the end of a frame of exact length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= sel_rise_i && (cnt_q == CNT_W'(WORD_W));
        end
    end

    // Present the oldest bit on each falling clock inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo_q <= 1'b0;
        end else if (frame_on && sck_fall_i) begin
            sdo_q <= shreg_q[WORD_W-1];
        end
    end

    assign word_o       = shreg_q;
    assign word_valid_o = valid_q;
    assign sdo_o        = sdo_q;

    // R6: a word is only flagged when the frame held exactly WORD_W clocks.
    p_exact_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> ($past(cnt_q) == CNT_W'(WORD_W)));

    // R11: the chaining output follows the oldest shift-register bit.
    p_sdo_msb_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_on && sck_fall_i) |=> (sdo_q == $past(shreg_q[WORD_W-1])));
endmodule

// File: rtl/code_regs.sv
// Module: code_regs
// Double-buffered code storage: a staging register and an output register,
// updated from a completed word according to its command field.
// Assumes: word_valid_i is a one-cycle pulse with stable cmd and data.
module code_regs
    import dac_ctrl_pkg::*;
#(
    parameter int CODE_W = dac_ctrl_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid_i,
    input  cmd_e              cmd_i,
    input  logic [CODE_W-1:0] data_i,
    output logic [CODE_W-1:0] stage_o,
    output logic [CODE_W-1:0] out_o
);
    logic [CODE_W-1:0] stage_q;
    logic [CODE_W-1:0] out_q;

    // Staging register: written by the stage-only and write-both commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (word_valid_i && (cmd_i == CMD_STAGE || cmd_i == CMD_BOTH)) begin
            stage_q <= data_i;
        end
    end

    // Output register: written by write-both, copied from staging on transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (word_valid_i) begin
            case (cmd_i)
                CMD_BOTH: out_q <= data_i;
                CMD_XFER: out_q <= stage_q;
                default:  out_q <= out_q;
            endcase
        end
    end

    assign stage_o = stage_q;
    assign out_o   = out_q;

    // R2: a stage-only write never moves the output code.
    p_stage_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_i && cmd_i == CMD_STAGE) |=> $stable(out_q));

    // R3: a transfer makes the output equal to the previous staging value.
    p_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_i && cmd_i == CMD_XFER) |=> (out_q == $past(stage_q)));

    // R4: write-both lands the same data in both registers.
    p_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_i && cmd_i == CMD_BOTH) |=> (out_q == $past(data_i) && stage_q == $past(data_i)));

    // R5: a sleep command leaves both registers untouched.
    p_sleep_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_i && cmd_i == CMD_SLEEP) |=> ($stable(out_q) && $stable(stage_q)));
endmodule

// File: rtl/sleep_ctrl.sv
// Module: sleep_ctrl
// Holds the sleep state. Entry comes from the sleep pin or the sleep command,
// both gated by the enable pin; exit comes from a falling enable edge (highest
// priority) or a write-both command. A held pin request outranks a write-both.
// Assumes: inputs are synchronised; lock_fall_i is a one-cycle pulse.
module sleep_ctrl
    import dac_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic word_valid_i,
    input  cmd_e cmd_i,
    input  logic pin_req_i,    // synchronised sleep_pin
    input  logic allow_i,      // synchronised sleep_allow
    input  logic allow_fall_i,
    output logic asleep_o
);
    logic asleep_q;
    logic cmd_sleep;
    logic cmd_wake;

    assign cmd_sleep = word_valid_i && (cmd_i == CMD_SLEEP);
    assign cmd_wake  = word_valid_i && (cmd_i == CMD_BOTH);

    // Update the sleep state by fixed priority: enable fall, pin, command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asleep_q <= 1'b0;
        end else if (allow_fall_i) begin
            asleep_q <= 1'b0;
        end else if (allow_i && pin_req_i) begin
            asleep_q <= 1'b1;
        end else if (allow_i && cmd_sleep) begin
            asleep_q <= 1'b1;
        end else if (cmd_wake) begin
            asleep_q <= 1'b0;
        end
    end

    assign asleep_o = asleep_q;

    // R9: a falling enable edge always wakes the block.
    p_fall_wakes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        allow_fall_i |=> !asleep_q);

    // R8: with the enable low, an awake block stays awake.
    p_locked_awake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!allow_i && !asleep_q) |=> !asleep_q);

    // R7: an enabled pin request puts the block to sleep.
    p_pin_enters_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (allow_i && pin_req_i && !allow_fall_i) |=> asleep_q);

    // R7/R10: asleep, only an enable fall or write-both can wake.
    p_stay_asleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep_q && !allow_fall_i && !cmd_wake) |=> asleep_q);
endmodule

// File: rtl/dac_serial_ctrl.sv
// Module: dac_serial_ctrl (top)
// Serial control front-end of a 14-bit DAC: pin synchronisers, word shifter,
// double-buffered code registers and sleep control.
// Assumes: sclk and cs_n each hold a level for at least four clk cycles.
module dac_serial_ctrl
    import dac_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              sleep_pin,
    input  logic              sleep_allow,
    output logic              sdo,
    output logic [CODE_W-1:0] dac_code,
    output logic              active
);
    localparam int PIN_N   = 5;
    localparam int P_CS    = 0;
    localparam int P_SCK   = 1;
    localparam int P_SDI   = 2;
    localparam int P_SLP   = 3;
    localparam int P_ALLOW = 4;
    localparam logic [PIN_N-1:0] PIN_RST = PIN_N'(1) << P_CS;

    logic [PIN_N-1:0]  pin_lvl, pin_rise, pin_fall;
    logic [WORD_W-1:0] word;
    logic              word_valid;
    cmd_e              cmd;
    logic [CODE_W-1:0] stage_code;
    logic              asleep;

    pin_sync #(
        .WIDTH  (PIN_N),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({sleep_allow, sleep_pin, sdi, sclk, cs_n}),
        .lvl_o (pin_lvl),
        .rise_o(pin_rise),
        .fall_o(pin_fall)
    );

    serial_shifter #(
        .WORD_W(WORD_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_lvl_i   (pin_lvl[P_CS]),
        .sel_fall_i  (pin_fall[P_CS]),
        .sel_rise_i  (pin_rise[P_CS]),
        .sck_rise_i  (pin_rise[P_SCK]),
        .sck_fall_i  (pin_fall[P_SCK]),
        .sdi_lvl_i   (pin_lvl[P_SDI]),
        .word_o      (word),
        .word_valid_o(word_valid),
        .sdo_o       (sdo)
    );

    assign cmd = cmd_e'(word[WORD_W-1 -: CMD_W]);

    code_regs #(
        .CODE_W(CODE_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_valid_i(word_valid),
        .cmd_i       (cmd),
        .data_i      (word[CODE_W-1:0]),
        .stage_o     (stage_code),
        .out_o       (dac_code)
    );

    sleep_ctrl u_sleep (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_valid_i(word_valid),
        .cmd_i       (cmd),
        .pin_req_i   (pin_lvl[P_SLP]),
        .allow_i     (pin_lvl[P_ALLOW]),
        .allow_fall_i(pin_fall[P_ALLOW]),
        .asleep_o    (asleep)
    );

    assign active = ~asleep;

    // R9: the output code survives a wake-up by enable fall.
    p_wake_keeps_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_fall[P_ALLOW] && !word_valid) |=> $stable(dac_code));

    // R10: asleep, a staging write keeps the block asleep.
    p_sleep_stage_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && word_valid && cmd == CMD_STAGE && !pin_fall[P_ALLOW]) |=> !active);
endmodule

// File: tb/dac_serial_ctrl_tb_top.sv
// Scoreboard bench: driver tasks push expected (code, active) items,
// a monitor pops them when due and compares against the ports.
module dac_serial_ctrl_tb_top;
    localparam int CW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic          sleep_pin = 1'b0, sleep_allow = 1'b0;
    logic          sdo;
    logic [CW-1:0] dac_code;
    logic          active;

    always #4 clk = ~clk;  // 125 MHz

    dac_serial_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sleep_pin(sleep_pin), .sleep_allow(sleep_allow),
        .sdo(sdo), .dac_code(dac_code), .active(active)
    );

    typedef struct {
        logic [CW-1:0] code;
        logic          act;
        int            due;
        string         tag;
    } exp_t;

    exp_t          sb_q[$];
    int            total = 0, bad = 0, cyc = 0;
    logic [CW-1:0] m_stage = '0, m_out = '0;
    logic          m_sleep = 1'b0, m_pin = 1'b0, m_allow = 1'b0;

    // Monitor: pop due items and compare against the ports.
    always @(negedge clk) begin
        cyc++;
        if (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_t it;
            it = sb_q.pop_front();
            total++;
            if (dac_code !== it.code || active !== it.act) begin
                bad++;
                $display("FAIL %s: code=%h active=%b expected code=%h active=%b",
                         it.tag, dac_code, active, it.code, it.act);
            end
        end
    end

    task automatic push_exp(input string tag);
        exp_t it;
        it.code = m_out; it.act = ~m_sleep; it.due = cyc + 8; it.tag = tag;
        sb_q.push_back(it);
        repeat (10) @(negedge clk);
    endtask

    task automatic model_word(input logic [15:0] w);
        case (w[15:14])
            2'b00: m_stage = w[13:0];
            2'b01: m_out = m_stage;
            2'b10: begin m_stage = w[13:0]; m_out = w[13:0]; m_sleep = 1'b0; end
            default: if (m_allow) m_sleep = 1'b1;
        endcase
        if (m_allow && m_pin) m_sleep = 1'b1;
    endtask

    // Driver: one frame of n bits, MSB of the n-bit value first.
    task automatic frame(input int n, input logic [31:0] d, input string tag);
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sdi = d[n-1-i];
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (6) @(negedge clk);
        if (n >= 16) begin
            total++;
            if (sdo !== d[15]) begin
                bad++;
                $display("FAIL R11 (%s): sdo=%b expected %b", tag, sdo, d[15]);
            end
        end
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        if (n == 16) model_word(d[15:0]);
        push_exp(tag);
    endtask

    task automatic set_pins(input logic slp, input logic alw, input string tag);
        logic was;
        was = m_allow;
        @(negedge clk);
        sleep_pin = slp; sleep_allow = alw;
        m_pin = slp; m_allow = alw;
        if (was && !alw) m_sleep = 1'b0;
        else if (alw && slp) m_sleep = 1'b1;
        push_exp(tag);
    endtask

    initial begin
        repeat (200000) @(negedge clk);
        bad++; total++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        total++;
        if (dac_code !== '0 || active !== 1'b1 || sdo !== 1'b0) begin
            bad++;
            $display("FAIL R1: code=%h active=%b sdo=%b expected 0000 1 0", dac_code, active, sdo);
        end
        frame(16, 32'h1234, "R2 stage only");
        frame(16, 32'h4000, "R3 transfer");
        frame(16, 32'hBFFF, "R4 R12 both full scale");
        frame(15, 32'h0012, "R6 15-bit frame");
        frame(17, 32'h08024, "R6 17-bit frame");
        frame(16, 32'h4000, "R6 staging untouched by bad frames");
        frame(16, 32'h8001, "R12 code one");
        set_pins(1'b0, 1'b1, "enable high no change");
        frame(16, 32'hC555, "R5 sleep command");
        frame(16, 32'h4000, "R5 R10 data of sleep ignored");
        frame(16, 32'h0100, "R10 stage while asleep");
        frame(16, 32'h4000, "R10 transfer while asleep");
        frame(16, 32'h8AAA, "R4 write both wakes");
        set_pins(1'b1, 1'b1, "R7 pin sleep");
        frame(16, 32'h8123, "R4 pin held blocks wake");
        set_pins(1'b0, 1'b1, "R7 pin low stays asleep");
        set_pins(1'b0, 1'b0, "R9 enable fall wakes code kept");
        set_pins(1'b1, 1'b0, "R8 pin ignored when locked");
        frame(16, 32'hC000, "R8 sleep command ignored when locked");
        set_pins(1'b0, 1'b0, "R8 pin released");
        set_pins(1'b0, 1'b1, "enable high again");
        frame(16, 32'hC3FF, "R5 sleep again");
        set_pins(1'b0, 1'b0, "R9 second enable fall");
        wait (sb_q.size() == 0);
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule